// File: doc/BRIEF.md
# Register-Mapped Serial Transceiver

This block is an asynchronous serial transceiver that software controls through seven byte-addressed registers on a simple 32-bit bus. A single-cycle select with a write flag performs each access. Read data is combinational. A read of the data address removes the oldest received character.

The transmit and receive engines each time a bit as sixteen ticks of their own prescaler. The prescaler reloads from a 16-bit divisor, so one bit lasts (divisor+1)*16 clocks. The divisor is staged in two byte registers and becomes active only when the format register is written. The format register selects:
- 5 to 8 data bits,
- optional even or odd parity,
- one or two stop bits,
- a forced-low break output,
- 16-entry FIFOs, or one-entry holding registers when the FIFOs are off.

Each received character carries its own framing, parity and break flags. When the character is read, those flags are copied into the error register. Overrun is sticky in the same register. Any write to the error register clears all four bits. The three modem inputs pass through two flip-flops and appear in the flag register, beside the FIFO and busy indications.

Top module: `lcr_uart`

## Requirements
- R1: After reset, txd is 1, the error register reads 0, and the flag register reads 0x90 (bit 7 transmit empty and bit 4 receive empty set, with the modem inputs low).
- R2: One serial bit lasts (D+1)*16 clocks. D is the 16-bit divisor: bits 15:8 from offset 0x0C and bits 7:0 from offset 0x10. A staged divisor takes effect only on the next write to the format register at 0x08.
- R3: A transmitted frame is one low start bit, then the data bits LSB first, then the optional parity bit, then one or two high stop bits. The word length is 5 + format[6:5]. Format bit 3 selects two stop bits.
- R4: Format bit 1 enables parity. Format bit 2 set gives even parity, so the data ones plus the parity bit form an even count; clear gives odd parity.
- R5: Format bit 0 drives txd low while the block is enabled.
- R6: With control bit 0 (offset 0x14) clear, txd is 1 and no character is received.
- R7: A received character is returned in bits 7:0 of a read at offset 0x00. The flag register at 0x18 has bit 4 (receive empty) clear while a character waits.
- R8: Reading a character loads its framing error (stop bit sampled low) into error bit 0 and its parity error into error bit 1. The error register is at offset 0x04.
- R9: A frame whose every sample, stop bits included, is low is received as data 0 with error bit 2 (break) set. Error bit 0 is also set.
- R10: A character that arrives while the receive buffer is full is discarded and sets error bit 3. Bit 3 stays set until the error register is cleared.
- R11: A write of any value to offset 0x04 clears all four error bits.
- R12: With format bit 4 clear, each direction holds one character. Flag bit 5 (transmit full) sets after one write, and flag bit 6 (receive full) sets after one received character.
- R13: With format bit 4 set, each direction holds FIFO_DEPTH characters and keeps their order. Transmit full is set only when FIFO_DEPTH characters are queued.
- R14: Flag bits 0, 1 and 2 follow the CTS, DSR and DCD inputs within three clocks. Flag bit 3 is set while a frame is being transmitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data (bits 7:0 used) |
| bus_rdata | output | 32 | Combinational read data |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| cts_in | input | 1 | Clear-to-send modem input |
| dsr_in | input | 1 | Data-set-ready modem input |
| dcd_in | input | 1 | Carrier-detect modem input |

## Verification
The bench builds the block with FIFO_DEPTH set to 4. This makes the full-FIFO flag and the overrun discard reachable after a handful of frames. Most tests program a divisor of 0, so a bit lasts 16 clocks and frames stay short. The divisor-timing test programs divisors 1 and 2 and checks 32- and 48-clock bits. It also checks that a staged divisor is ignored until the format register is written.

// File: rtl/lcr_uart_pkg.sv
package lcr_uart_pkg;

  localparam logic [7:0] OFS_DATA = 8'h00;
  localparam logic [7:0] OFS_ERR  = 8'h04;
  localparam logic [7:0] OFS_FMT  = 8'h08;
  localparam logic [7:0] OFS_DIVH = 8'h0C;
  localparam logic [7:0] OFS_DIVL = 8'h10;
  localparam logic [7:0] OFS_CTRL = 8'h14;
  localparam logic [7:0] OFS_FLAG = 8'h18;

  // format register layout, bit 6 down to bit 0
  typedef struct packed {
    logic [1:0] wlen;
    logic       fifo_en;
    logic       two_stop;
    logic       even;
    logic       par_en;
    logic       brk;
  } fmt_t;

  typedef struct packed {
    logic       brk_err;
    logic       par_err;
    logic       frm_err;
    logic [7:0] data;
  } rx_word_t;

  function automatic logic [3:0] data_bits(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

  function automatic logic parity_of(input logic [7:0] d, input logic [1:0] code,
                                     input logic even);
    logic [7:0] mask;
    logic p;
    mask = 8'hFF >> (2'd3 - code);
    p = ^(d & mask);
    return even ? p : ~p;
  endfunction

endpackage

// File: rtl/lcr_fifo.sv
module lcr_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_one,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = cap_one ? !empty : (count == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R13: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

endmodule

// File: rtl/lcr_tx.sv
module lcr_tx import lcr_uart_pkg::*; #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       wlen,
  input  logic             par_en,
  input  logic             even,
  input  logic             two_stop,
  input  logic             brk,
  input  logic [DIV_W-1:0] div,
  input  logic             avail,
  input  logic [7:0]       data,
  output logic             take,
  output logic             busy,
  output logic             txd
);
  typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP} tstate_t;

  tstate_t          state;
  logic [DIV_W-1:0] pcnt;
  logic [3:0]       sub, idx;
  logic [7:0]       shreg;
  logic             line, par_q, stop2;
  logic             tick, bit_end;

  assign tick    = (pcnt == div);
  assign bit_end = tick && (sub == 4'd15);
  assign take    = en && avail && (state == T_IDLE);
  assign busy    = (state != T_IDLE);
  assign txd     = !en ? 1'b1 : (brk ? 1'b0 : line);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= T_IDLE;
      line  <= 1'b1;
      pcnt  <= '0;
      sub   <= '0;
      idx   <= '0;
      shreg <= '0;
      par_q <= 1'b0;
      stop2 <= 1'b0;
    end else if (!en) begin
      state <= T_IDLE;
      line  <= 1'b1;
    end else if (take) begin
      state <= T_START;
      line  <= 1'b0;
      shreg <= data;
      par_q <= parity_of(data, wlen, even);
      pcnt  <= '0;
      sub   <= '0;
      idx   <= '0;
    end else if (state != T_IDLE) begin
      pcnt <= tick ? '0 : pcnt + 1'b1;
      if (tick) sub <= sub + 1'b1;
      if (bit_end) begin
        case (state)
          T_START: begin
            state <= T_DATA;
            line  <= shreg[0];
          end
          T_DATA: begin
            if (idx == data_bits(wlen) - 4'd1) begin
              if (par_en) begin
                state <= T_PAR;
                line  <= par_q;
              end else begin
                state <= T_STOP;
                line  <= 1'b1;
                stop2 <= two_stop;
              end
            end else begin
              idx   <= idx + 1'b1;
              shreg <= shreg >> 1;
              line  <= shreg[1];
            end
          end
          T_PAR: begin
            state <= T_STOP;
            line  <= 1'b1;
            stop2 <= two_stop;
          end
          T_STOP: begin
            if (stop2) stop2 <= 1'b0;
            else       state <= T_IDLE;
          end
          default: state <= T_IDLE;
        endcase
      end
    end
  end

  // R3: a frame begins with a low start bit on the line
  assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!txd || !en));

endmodule

// File: rtl/lcr_rx.sv
module lcr_rx import lcr_uart_pkg::*; #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       wlen,
  input  logic             par_en,
  input  logic             even,
  input  logic             two_stop,
  input  logic [DIV_W-1:0] div,
  input  logic             rxd_s,
  output logic             done,
  output rx_word_t         word
);
  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP, R_HOLD} rstate_t;

  rstate_t          state;
  logic [DIV_W-1:0] pcnt;
  logic [3:0]       sub, idx;
  logic [7:0]       dat;
  logic             any_one, fe, pe, stop2;
  logic             tick, samp, confirm;

  assign tick    = (pcnt == div);
  assign samp    = tick && (sub == 4'd15);
  assign confirm = tick && (sub == 4'd7);
  assign word    = '{brk_err: !any_one, par_err: pe, frm_err: fe, data: dat};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= R_IDLE;
      pcnt    <= '0;
      sub     <= '0;
      idx     <= '0;
      dat     <= '0;
      any_one <= 1'b0;
      fe      <= 1'b0;
      pe      <= 1'b0;
      stop2   <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        state <= R_IDLE;
      end else if (state == R_IDLE) begin
        if (!rxd_s) begin
          state   <= R_START;
          pcnt    <= '0;
          sub     <= '0;
          idx     <= '0;
          dat     <= '0;
          any_one <= 1'b0;
          fe      <= 1'b0;
          pe      <= 1'b0;
        end
      end else begin
        pcnt <= tick ? '0 : pcnt + 1'b1;
        if (tick) sub <= sub + 1'b1;
        case (state)
          R_START: if (confirm) begin
            if (rxd_s) state <= R_IDLE;
            else begin
              state <= R_DATA;
              sub   <= '0;
            end
          end
          R_DATA: if (samp) begin
            dat[idx[2:0]] <= rxd_s;
            any_one       <= any_one | rxd_s;
            if (idx == data_bits(wlen) - 4'd1) begin
              state <= par_en ? R_PAR : R_STOP;
              stop2 <= two_stop;
            end else begin
              idx <= idx + 1'b1;
            end
          end
          R_PAR: if (samp) begin
            pe      <= (rxd_s != parity_of(dat, wlen, even));
            any_one <= any_one | rxd_s;
            state   <= R_STOP;
          end
          R_STOP: if (samp) begin
            any_one <= any_one | rxd_s;
            if (!rxd_s) fe <= 1'b1;
            if (stop2) stop2 <= 1'b0;
            else begin
              done  <= 1'b1;
              state <= rxd_s ? R_IDLE : R_HOLD;
            end
          end
          R_HOLD: if (rxd_s) state <= R_IDLE;
          default: state <= R_IDLE;
        endcase
      end
    end
  end

  // R6: a character is only delivered while the block is enabled
  assert_rx_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(en));

endmodule

// File: rtl/lcr_uart.sv
module lcr_uart import lcr_uart_pkg::*; #(
  parameter int FIFO_DEPTH = 16,
  parameter int DIV_W      = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        rxd,
  output logic        txd,
  input  logic        cts_in,
  input  logic        dsr_in,
  input  logic        dcd_in
);
  localparam int RXW = $bits(rx_word_t);

  fmt_t             fmt_q;
  logic [7:0]       div_hi_q, div_lo_q;
  logic [DIV_W-1:0] div_act;
  logic             en_q;
  logic [3:0]       err_q;
  logic             rx_meta, rx_sync;
  logic [2:0]       mdm_meta, mdm_sync;

  logic wr_acc, rd_acc, st_clr, rx_pop, tx_push;
  logic tx_take, tx_busy, tx_empty, tx_full;
  logic [7:0] tx_head;
  logic rx_done, rx_empty, rx_full, ovr_evt;
  rx_word_t rx_word, rx_head;
  logic [RXW-1:0] rx_head_bits;
  logic [7:0] flags;
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[31:8];
  assign wr_acc  = bus_sel && bus_wr;
  assign rd_acc  = bus_sel && !bus_wr;
  assign st_clr  = wr_acc && (bus_addr == OFS_ERR);
  assign tx_push = wr_acc && (bus_addr == OFS_DATA);
  assign rx_pop  = rd_acc && (bus_addr == OFS_DATA);
  assign ovr_evt = rx_done && rx_full;
  assign rx_head = rx_word_t'(rx_head_bits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q    <= '0;
      div_hi_q <= '0;
      div_lo_q <= '0;
      div_act  <= '0;
      en_q     <= 1'b0;
    end else if (wr_acc) begin
      case (bus_addr)
        OFS_FMT: begin
          fmt_q   <= fmt_t'(bus_wdata[6:0]);
          div_act <= DIV_W'({div_hi_q, div_lo_q});
        end
        OFS_DIVH: div_hi_q <= bus_wdata[7:0];
        OFS_DIVL: div_lo_q <= bus_wdata[7:0];
        OFS_CTRL: en_q     <= bus_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
    end else if (st_clr) begin
      err_q <= '0;
    end else begin
      if (ovr_evt) err_q[3] <= 1'b1;
      if (rx_pop && !rx_empty)
        err_q[2:0] <= {rx_head.brk_err, rx_head.par_err, rx_head.frm_err};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_meta  <= 1'b1;
      rx_sync  <= 1'b1;
      mdm_meta <= '0;
      mdm_sync <= '0;
    end else begin
      rx_meta  <= rxd;
      rx_sync  <= rx_meta;
      mdm_meta <= {dcd_in, dsr_in, cts_in};
      mdm_sync <= mdm_meta;
    end
  end

  lcr_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
    .clk(clk), .rst_n(rst_n), .cap_one(!fmt_q.fifo_en),
    .push(tx_push), .wdata(bus_wdata[7:0]), .pop(tx_take),
    .head(tx_head), .empty(tx_empty), .full(tx_full));

  lcr_fifo #(.DEPTH(FIFO_DEPTH), .W(RXW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .cap_one(!fmt_q.fifo_en),
    .push(rx_done), .wdata(rx_word), .pop(rx_pop),
    .head(rx_head_bits), .empty(rx_empty), .full(rx_full));

  lcr_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(en_q), .wlen(fmt_q.wlen), .par_en(fmt_q.par_en),
    .even(fmt_q.even), .two_stop(fmt_q.two_stop), .brk(fmt_q.brk), .div(div_act),
    .avail(!tx_empty), .data(tx_head), .take(tx_take), .busy(tx_busy), .txd(txd));

  lcr_rx #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(en_q), .wlen(fmt_q.wlen), .par_en(fmt_q.par_en),
    .even(fmt_q.even), .two_stop(fmt_q.two_stop), .div(div_act),
    .rxd_s(rx_sync), .done(rx_done), .word(rx_word));

  assign flags = {tx_empty, rx_full, tx_full, rx_empty, tx_busy, mdm_sync};

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_DATA: bus_rdata[7:0] = rx_head.data;
      OFS_ERR:  bus_rdata[3:0] = err_q;
      OFS_FMT:  bus_rdata[6:0] = fmt_q;
      OFS_DIVH: bus_rdata[7:0] = div_hi_q;
      OFS_DIVL: bus_rdata[7:0] = div_lo_q;
      OFS_CTRL: bus_rdata[0]   = en_q;
      OFS_FLAG: bus_rdata[7:0] = flags;
      default:  bus_rdata = '0;
    endcase
  end

  assert_err_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    st_clr |=> (err_q == 4'd0));

  assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_evt && !st_clr) |=> err_q[3]);

endmodule

// File: tb/lcr_uart_test.sv
module lcr_uart_test;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic rxd = 1'b1, txd;
  logic cts_in = 1'b0, dsr_in = 1'b0, dcd_in = 1'b0;

  int checks = 0, errs = 0, bitc = 16;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  lcr_uart #(.FIFO_DEPTH(DEPTH), .DIV_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rxd(rxd), .txd(txd),
    .cts_in(cts_in), .dsr_in(dsr_in), .dcd_in(dcd_in));

  function automatic logic [31:0] fmt(int wl, bit fen, bit two, bit ev, bit pen, bit brk);
    return {25'b0, 2'(wl - 5), fen, two, ev, pen, brk};
  endfunction

  function automatic bit exp_par(logic [7:0] d, int nd, bit ev);
    bit p = 1'b0;
    for (int i = 0; i < nd; i++) p ^= d[i];
    return ev ? p : !p;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic cap(int nd, bit pen, int ns, output logic [7:0] d, output logic p,
                     output bit ok);
    int guard = 0;
    while (txd !== 1'b0 && guard < 5000) begin @(negedge clk); guard++; end
    repeat (bitc / 2) @(negedge clk);
    ok = (txd === 1'b0);
    d = '0; p = 1'b0;
    for (int i = 0; i < nd; i++) begin repeat (bitc) @(negedge clk); d[i] = txd; end
    if (pen) begin repeat (bitc) @(negedge clk); p = txd; end
    for (int s = 0; s < ns; s++) begin repeat (bitc) @(negedge clk); ok &= (txd === 1'b1); end
  endtask

  task automatic send(logic [7:0] d, int nd, bit pen, bit pbit, int ns, bit stopv);
    @(negedge clk); rxd = 1'b0;
    repeat (bitc) @(negedge clk);
    for (int i = 0; i < nd; i++) begin rxd = d[i]; repeat (bitc) @(negedge clk); end
    if (pen) begin rxd = pbit; repeat (bitc) @(negedge clk); end
    for (int s = 0; s < ns; s++) begin rxd = stopv; repeat (bitc) @(negedge clk); end
    rxd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic start_width(output int cnt);
    int guard = 0;
    while (txd !== 1'b0 && guard < 5000) begin @(negedge clk); guard++; end
    cnt = 0;
    while (txd === 1'b0 && cnt < 5000) begin @(negedge clk); cnt++; end
    repeat (bitc * 10) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 txd idle", {31'b0, txd}, 32'd1);
    rd(8'h18, v); chk("R1 flags", v, 32'h90);
    rd(8'h04, v); chk("R1 errors", v, 32'h0);
  endtask

  task automatic t_modem;
    logic [31:0] v;
    cts_in = 1'b1; dcd_in = 1'b1;
    repeat (3) @(negedge clk);
    rd(8'h18, v); chk("R14 modem flags", v & 32'h7, 32'h5);
    cts_in = 1'b0; dsr_in = 1'b1; dcd_in = 1'b0;
    repeat (3) @(negedge clk);
    rd(8'h18, v); chk("R14 modem flags 2", v & 32'h7, 32'h2);
    dsr_in = 1'b0;
  endtask

  task automatic t_tx_basic;
    logic [31:0] v; logic [7:0] d; logic p; bit ok;
    wr(8'h14, 1);
    wr(8'h08, fmt(8, 1, 0, 0, 0, 0));
    wr(8'h00, 32'hA5);
    rd(8'h18, v); chk("R14 busy flag", (v >> 3) & 1, 32'd1);
    cap(8, 0, 1, d, p, ok);
    chk("R3 8N1 data", d, 8'hA5); chk("R3 8N1 start/stop", ok, 1);
    repeat (bitc) @(negedge clk);
    rd(8'h18, v); chk("R14 busy clear", (v >> 3) & 1, 32'd0);
  endtask

  task automatic t_tx_parity;
    logic [7:0] d; logic p; bit ok;
    wr(8'h08, fmt(7, 1, 1, 1, 1, 0));
    wr(8'h00, 32'h34);
    cap(7, 1, 2, d, p, ok);
    chk("R3 7E2 data", d, 8'h34); chk("R3 7E2 stops", ok, 1);
    chk("R4 even parity", p, exp_par(8'h34, 7, 1));
    wr(8'h08, fmt(5, 1, 0, 0, 1, 0));
    wr(8'h00, 32'h16);
    cap(5, 1, 1, d, p, ok);
    chk("R3 5O1 data", d, 8'h16);
    chk("R4 odd parity", p, exp_par(8'h16, 5, 0));
  endtask

  task automatic t_divisor;
    int c;
    wr(8'h10, 1); wr(8'h08, fmt(8, 1, 0, 0, 0, 0)); bitc = 32;
    wr(8'h00, 1); start_width(c); chk("R2 divisor 1 bit length", c, 32);
    wr(8'h10, 2);
    wr(8'h00, 1); start_width(c); chk("R2 staged divisor inactive", c, 32);
    wr(8'h08, fmt(8, 1, 0, 0, 0, 0)); bitc = 48;
    wr(8'h00, 1); start_width(c); chk("R2 divisor 2 bit length", c, 48);
    wr(8'h10, 0); wr(8'h08, fmt(8, 1, 0, 0, 0, 0)); bitc = 16;
  endtask

  task automatic t_break_and_disable;
    logic [31:0] v;
    wr(8'h08, fmt(8, 1, 0, 0, 0, 1));
    repeat (2) @(negedge clk);
    chk("R5 break drives low", {31'b0, txd}, 32'd0);
    wr(8'h14, 0);
    repeat (2) @(negedge clk);
    chk("R6 disabled txd high", {31'b0, txd}, 32'd1);
    wr(8'h08, fmt(8, 1, 0, 0, 0, 0));
    send(8'h3C, 8, 0, 0, 1, 1);
    rd(8'h18, v); chk("R6 no reception when disabled", (v >> 4) & 1, 32'd1);
    wr(8'h14, 1);
  endtask

  task automatic t_rx_basic;
    logic [31:0] v;
    send(8'h5A, 8, 0, 0, 1, 1);
    rd(8'h18, v); chk("R7 rx not empty", (v >> 4) & 1, 32'd0);
    rd(8'h00, v); chk("R7 rx data", v, 32'h5A);
    rd(8'h18, v); chk("R7 rx empty after read", (v >> 4) & 1, 32'd1);
    rd(8'h04, v); chk("R8 clean char no errors", v, 32'h0);
  endtask

  task automatic t_rx_errors;
    logic [31:0] v;
    wr(8'h08, fmt(6, 1, 0, 0, 1, 0));
    send(8'h2B, 6, 1, !exp_par(8'h2B, 6, 0), 1, 1);
    rd(8'h00, v); chk("R8 parity char data", v, 32'h2B);
    rd(8'h04, v); chk("R8 parity error bit", v, 32'h2);
    wr(8'h04, 32'h12345678);
    rd(8'h04, v); chk("R11 clear by write", v, 32'h0);
    wr(8'h08, fmt(8, 1, 0, 0, 0, 0));
    send(8'h81, 8, 0, 0, 1, 0);
    rd(8'h00, v); chk("R8 framing char data", v, 32'h81);
    rd(8'h04, v); chk("R8 framing error bit", v, 32'h1);
    wr(8'h04, 0);
    @(negedge clk); rxd = 1'b0;
    repeat (bitc * 12) @(negedge clk);
    rxd = 1'b1;
    repeat (bitc) @(negedge clk);
    rd(8'h00, v); chk("R9 break data zero", v, 32'h0);
    rd(8'h04, v); chk("R9 break and framing bits", v, 32'h5);
    wr(8'h04, 0);
  endtask

  task automatic t_holding;
    logic [31:0] v; logic [7:0] d; logic p; bit ok;
    wr(8'h14, 0);
    wr(8'h08, fmt(8, 0, 0, 0, 0, 0));
    wr(8'h00, 32'h11);
    rd(8'h18, v); chk("R12 tx full after one", (v >> 5) & 1, 32'd1);
    chk("R12 tx not empty", (v >> 7) & 1, 32'd0);
    wr(8'h00, 32'h22);
    wr(8'h14, 1);
    cap(8, 0, 1, d, p, ok); chk("R12 held tx char", d, 8'h11);
    repeat (bitc * 2) @(negedge clk);
    rd(8'h18, v); chk("R12 second write dropped", (v >> 7) & 1, 32'd1);
    send(8'h66, 8, 0, 0, 1, 1);
    rd(8'h18, v); chk("R12 rx full after one", (v >> 6) & 1, 32'd1);
    send(8'h77, 8, 0, 0, 1, 1);
    rd(8'h00, v); chk("R10 first char kept", v, 32'h66);
    rd(8'h04, v); chk("R10 overrun bit", v, 32'h8);
    rd(8'h18, v); chk("R10 extra char discarded", (v >> 4) & 1, 32'd1);
    wr(8'h04, 0);
  endtask

  task automatic t_fifo;
    logic [31:0] v; logic [7:0] d; logic p; bit ok;
    wr(8'h14, 0);
    wr(8'h08, fmt(8, 1, 0, 0, 0, 0));
    for (int i = 0; i < DEPTH - 1; i++) wr(8'h00, 32'h40 + i);
    rd(8'h18, v); chk("R13 not full below depth", (v >> 5) & 1, 32'd0);
    wr(8'h00, 32'h40 + DEPTH - 1);
    rd(8'h18, v); chk("R13 full at depth", (v >> 5) & 1, 32'd1);
    wr(8'h14, 1);
    for (int i = 0; i < DEPTH; i++) begin
      cap(8, 0, 1, d, p, ok); chk("R13 tx order", d, 8'(32'h40 + i));
    end
    for (int i = 0; i <= DEPTH; i++) send(8'(8'hC0 + i), 8, 0, 0, 1, 1);
    rd(8'h18, v); chk("R13 rx full flag", (v >> 6) & 1, 32'd1);
    for (int i = 0; i < DEPTH; i++) begin
      rd(8'h00, v); chk("R13 rx order", v, 32'hC0 + i);
    end
    rd(8'h04, v); chk("R10 overrun sticky", v, 32'h8);
    wr(8'h04, 32'hFF);
    rd(8'h04, v); chk("R11 clear overrun", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modem();
    t_tx_basic();
    t_tx_parity();
    t_divisor();
    t_break_and_disable();
    t_rx_basic();
    t_rx_errors();
    t_holding();
    t_fifo();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errs++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule